// File: doc/BRIEF.md
# Keyboard Controller Host Command Front End

This block is the register face of a legacy PC keyboard controller as the host CPU sees it. A simple byte bus with one shared address, a write strobe, a read strobe and separate write and read data paths reaches two ports. The data port is at offset 0x60. The command/status port is at offset 0x64. The block decodes command bytes and holds four pieces of state: a control register, an output-port register, a "next data byte is a command argument" flag and the latched command byte. It puts its answers into a small reply buffer, which the host drains by reading the data port.

Some commands take two steps. The host first writes the command to the command port, which sets the argument flag. Its next write to the data port then supplies the argument. A data-port write made while the flag is clear goes to the keyboard itself. The block answers every such byte with the acknowledge code and one interrupt pulse. The CPU-reset command produces a one-cycle reset request. Saturating counters track accepted writes, rejected writes and reset requests.

Top module: `kbc_cmd_front`

## Requirements
- R1: Writes are decoded only at address 0x60 (data) and 0x64 (command/status). A write to any other address changes no state, raises no pulse and adds one to the missed-write count.
- R2: A write whose length input is not 1 byte is dropped at any address. It changes no state and adds one to the missed-write count.
- R3: Writing 0xFE to the command port gives a `cpu_reset_req` pulse exactly one cycle long in the cycle after the write. It also adds one to both the reset count and the accepted count.
- R4: Writing 0x20 to the command port discards any pending reply and loads the control register. The next data-port read returns that byte.
- R5: Writing 0xD0 to the command port discards any pending reply and loads the output-port register as the only reply byte.
- R6: Writing 0x60 to the command port discards any pending reply and sets status bit 3. The next data-port write replaces the control register and clears bit 3.
- R7: Writing 0xD1 to the command port sets status bit 3 and keeps any pending reply. The next data-port write replaces the output-port register and clears bit 3.
- R8: A data-port write made while status bit 3 is clear discards any pending reply and loads 0xFA. It gives a `kbd_irq` pulse one cycle long in the cycle after the write.
- R9: A read of the status port returns {4'b0, bit 3 = argument flag, 2'b0, bit 0 = reply pending} and has no side effect. A data-port read removes the reply it returns, and returns 0x00 when no reply is pending. A read at any other address returns 0xFF.
- R10: Any other byte written to the command port is rejected and adds one to the missed-write count.
- R11: Every accepted write adds one to the accepted count. The three counters are CNT_W bits wide and hold at 2^CNT_W-1 instead of wrapping.
- R12: After reset the status reads 0x00, the counters read 0, the control register holds CTRL_INIT (0x00) and the output-port register holds OUTP_INIT (0x01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Access address, shared by reads and writes |
| bus_len | input | 3 | Write access length in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a data-port read removes the reply it returns |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cpu_reset_req | output | 1 | One-cycle CPU reset request |
| kbd_irq | output | 1 | One-cycle keyboard interrupt |
| acc_count | output | CNT_W (32) | Saturating count of accepted writes |
| miss_count | output | CNT_W (32) | Saturating count of rejected writes |
| reset_count | output | CNT_W (32) | Saturating count of reset requests |

## Verification
The bench runs a reference model beside the design. It sweeps all 256 command bytes, each followed by a data-port write, so every two-step pairing is exercised. A design that failed to clear the argument flag would treat a later keyboard byte as an argument, and the missing acknowledge would show up on the next read. The 0xD1 command following a pending acknowledge is the case for R7: a design that flushed the buffer there would show status bit 0 clear. The bench also sweeps addresses and access lengths to catch decode that is too loose, and it drives enough writes to push the narrow counters of the bench configuration past their limit. A design that wrapped would show a small count in place of the ceiling.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_RD_CTRL = 8'h20;
    localparam logic [7:0] OP_WR_CTRL = 8'h60;
    localparam logic [7:0] OP_RD_OUTP = 8'hD0;
    localparam logic [7:0] OP_WR_OUTP = 8'hD1;
    localparam logic [7:0] OP_CPU_RST = 8'hFE;
    localparam logic [7:0] KBD_ACK    = 8'hFA;
    localparam logic [7:0] RD_UNMAPPED = 8'hFF;

    typedef enum logic [1:0] {
        LOAD_NONE,
        LOAD_CTRL,
        LOAD_OUTP,
        LOAD_ACK
    } load_sel_e;

    typedef struct packed {
        logic      accept;
        logic      miss;
        logic      flush;
        load_sel_e load;
        logic      set_flag;
        logic      clr_flag;
        logic      wr_ctrl;
        logic      wr_outp;
        logic      cpu_rst;
        logic      kbd_irq;
    } kbc_act_t;

    function automatic logic [7:0] status_byte(input logic obf, input logic arg_flag);
        return {4'b0000, arg_flag, 2'b00, obf};
    endfunction

endpackage

// File: rtl/kbc_decode.sv
module kbc_decode
    import kbc_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        len,
    input  logic [7:0]        wdata,
    input  logic              arg_flag,
    input  logic [7:0]        pend_cmd,
    output kbc_act_t          act
);

    always_comb begin
        act = '0;
        if (wr_en) begin
            if (len != 3'd1) begin
                act.miss = 1'b1;
            end else if (addr == CMD_PORT) begin
                act.accept = 1'b1;
                case (wdata)
                    OP_CPU_RST: act.cpu_rst = 1'b1;
                    OP_RD_CTRL: begin
                        act.flush = 1'b1;
                        act.load  = LOAD_CTRL;
                    end
                    OP_RD_OUTP: begin
                        act.flush = 1'b1;
                        act.load  = LOAD_OUTP;
                    end
                    OP_WR_CTRL: begin
                        act.flush    = 1'b1;
                        act.set_flag = 1'b1;
                    end
                    OP_WR_OUTP: act.set_flag = 1'b1;
                    default: begin
                        act.accept = 1'b0;
                        act.miss   = 1'b1;
                    end
                endcase
            end else if (addr == DATA_PORT) begin
                act.accept = 1'b1;
                if (arg_flag) begin
                    act.clr_flag = 1'b1;
                    if (pend_cmd == OP_WR_CTRL)      act.wr_ctrl = 1'b1;
                    else if (pend_cmd == OP_WR_OUTP) act.wr_outp = 1'b1;
                end else begin
                    act.flush   = 1'b1;
                    act.load    = LOAD_ACK;
                    act.kbd_irq = 1'b1;
                end
            end else begin
                act.miss = 1'b1;
            end
        end
    end

endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    logic do_pop, do_push;
    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && ((cnt < CW'(DEPTH)) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            rp <= '0;
            if (push) begin
                mem[0] <= din;
                wp     <= nxt('0);
                cnt    <= CW'(1);
            end else begin
                wp  <= '0;
                cnt <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            if (do_push && !do_pop)      cnt <= cnt + CW'(1);
            else if (do_pop && !do_push) cnt <= cnt - CW'(1);
        end
    end

    assign nonempty = (cnt != '0);
    assign head     = mem[rp];

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    a_r4_flush_then_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flush)) |-> (cnt == ($past(push) ? CW'(1) : CW'(0))));

endmodule

// File: rtl/kbc_sat_cnt.sv
module kbc_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                     value <= '0;
        else if (inc && value != TOP) value <= value + W'(1);
    end

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (value >= $past(value)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(inc)) |-> $stable(value));

endmodule

// File: rtl/kbc_cmd_front.sv
module kbc_cmd_front
    import kbc_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               CNT_W     = 32,
    parameter int               BUF_DEPTH = 4,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [7:0]        CTRL_INIT = 8'h00,
    parameter logic [7:0]        OUTP_INIT = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_len,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              cpu_reset_req,
    output logic              kbd_irq,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  reset_count
);

    localparam int NCNT = 3;

    kbc_act_t   act;
    logic       arg_flag;
    logic [7:0] pend_cmd;
    logic [7:0] ctrl_q, outp_q;
    logic [7:0] load_byte;
    logic       buf_ne;
    logic [7:0] buf_head;
    logic       rd_pop;

    kbc_decode #(
        .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
    ) u_dec (
        .wr_en(bus_wr), .addr(bus_addr), .len(bus_len), .wdata(bus_wdata),
        .arg_flag(arg_flag), .pend_cmd(pend_cmd), .act(act)
    );

    always_comb begin
        case (act.load)
            LOAD_CTRL: load_byte = ctrl_q;
            LOAD_OUTP: load_byte = outp_q;
            LOAD_ACK:  load_byte = KBD_ACK;
            default:   load_byte = 8'h00;
        endcase
    end

    assign rd_pop = bus_rd && (bus_addr == DATA_PORT);

    kbc_outbuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_buf (
        .clk(clk), .rst(rst), .flush(act.flush),
        .push(act.load != LOAD_NONE), .din(load_byte),
        .pop(rd_pop), .head(buf_head), .nonempty(buf_ne)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_flag      <= 1'b0;
            pend_cmd      <= 8'h00;
            ctrl_q        <= CTRL_INIT;
            outp_q        <= OUTP_INIT;
            cpu_reset_req <= 1'b0;
            kbd_irq       <= 1'b0;
        end else begin
            if (act.set_flag) begin
                arg_flag <= 1'b1;
                pend_cmd <= bus_wdata;
            end else if (act.clr_flag) begin
                arg_flag <= 1'b0;
            end
            if (act.wr_ctrl) ctrl_q <= bus_wdata;
            if (act.wr_outp) outp_q <= bus_wdata;
            cpu_reset_req <= act.cpu_rst;
            kbd_irq       <= act.kbd_irq;
        end
    end

    always_comb begin
        if (bus_addr == CMD_PORT)       bus_rdata = status_byte(buf_ne, arg_flag);
        else if (bus_addr == DATA_PORT) bus_rdata = buf_ne ? buf_head : 8'h00;
        else                            bus_rdata = RD_UNMAPPED;
    end

    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_val [NCNT];
    assign cnt_inc = {act.cpu_rst, act.miss, act.accept};

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        kbc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .inc(cnt_inc[gi]), .value(cnt_val[gi])
        );
    end

    assign acc_count   = cnt_val[0];
    assign miss_count  = cnt_val[1];
    assign reset_count = cnt_val[2];

    a_r6_flag_cmd: assert property (@(posedge clk) disable iff (rst)
        arg_flag |-> (pend_cmd == OP_WR_CTRL || pend_cmd == OP_WR_OUTP));

    a_r3_reset_cause: assert property (@(posedge clk) disable iff (rst)
        cpu_reset_req |-> ($past(bus_wr) && $past(bus_len) == 3'd1 &&
                           $past(bus_addr) == CMD_PORT && $past(bus_wdata) == OP_CPU_RST));

    a_r8_irq_has_ack: assert property (@(posedge clk) disable iff (rst)
        kbd_irq |-> (buf_ne && buf_head == KBD_ACK));

    a_r2_wide_no_effect: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr) && $past(bus_len) != 3'd1) |->
            ($stable(ctrl_q) && $stable(outp_q) && $stable(arg_flag) && !cpu_reset_req && !kbd_irq));

endmodule

// File: tb/kbc_cmd_front_test.sv
`timescale 1ns/1ps
module kbc_cmd_front_test;

    localparam int CW = 10;
    localparam int CMAX = (1 << CW) - 1;
    localparam logic [15:0] PD = 16'h0060;
    localparam logic [15:0] PC = 16'h0064;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [2:0]  bus_len = 3'd1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic cpu_reset_req, kbd_irq;
    logic [CW-1:0] acc_count, miss_count, reset_count;

    always #2.5 clk = ~clk;

    kbc_cmd_front #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .cpu_reset_req(cpu_reset_req), .kbd_irq(kbd_irq),
        .acc_count(acc_count), .miss_count(miss_count), .reset_count(reset_count)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [7:0] m_ctrl = 8'h00, m_outp = 8'h01, m_cmd = 8'h00, m_buf = 8'h00;
    bit m_flag = 0, m_valid = 0;
    int m_acc = 0, m_miss = 0, m_rst = 0;
    string m_buf_tag = "R9";

    function automatic int sat(input int n);
        return (n > CMAX) ? CMAX : n;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] l);
        bit er = 0, ei = 0;
        string tag;
        // model
        if (l != 3'd1) begin m_miss++; tag = "R2"; end
        else if (a == PC) begin
            tag = "R10";
            case (d)
                8'hFE: begin m_acc++; m_rst++; er = 1; tag = "R3"; end
                8'h20: begin m_acc++; m_valid = 1; m_buf = m_ctrl; m_buf_tag = "R4"; tag = "R4"; end
                8'hD0: begin m_acc++; m_valid = 1; m_buf = m_outp; m_buf_tag = "R5"; tag = "R5"; end
                8'h60: begin m_acc++; m_valid = 0; m_flag = 1; m_cmd = d; tag = "R6"; end
                8'hD1: begin m_acc++; m_flag = 1; m_cmd = d; tag = "R7"; end
                default: m_miss++;
            endcase
        end else if (a == PD) begin
            m_acc++;
            if (m_flag) begin
                if (m_cmd == 8'h60) begin m_ctrl = d; tag = "R6"; end
                else begin m_outp = d; tag = "R7"; end
                m_flag = 0;
            end else begin
                m_valid = 1; m_buf = 8'hFA; m_buf_tag = "R8"; ei = 1; tag = "R8";
            end
        end else begin m_miss++; tag = "R1"; end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_len = l; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk({tag, " R3 reset pulse"}, int'(cpu_reset_req), int'(er));
        chk({tag, " R8 irq pulse"}, int'(kbd_irq), int'(ei));
        chk({tag, " R11 accepted count"}, int'(acc_count), sat(m_acc));
        chk({tag, " R1 missed count"}, int'(miss_count), sat(m_miss));
        chk({tag, " R3 reset count"}, int'(reset_count), sat(m_rst));
    endtask

    task automatic rd(input logic [15:0] a);
        int exp;
        string tag;
        if (a == PC) begin exp = {m_flag, 2'b00, m_valid}; tag = "R9 status"; end
        else if (a == PD) begin
            exp = m_valid ? m_buf : 0;
            tag = {m_valid ? m_buf_tag : "R9", " data read"};
            m_valid = 0;
        end else begin exp = 8'hFF; tag = "R9 unmapped"; end
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, int'(bus_rdata), exp);
        chk("R3 R8 pulses single cycle", int'(cpu_reset_req) + int'(kbd_irq), 0);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 acc_count", int'(acc_count), 0);
        chk("R12 miss_count", int'(miss_count), 0);
        chk("R12 reset_count", int'(reset_count), 0);
        rd(PC);
        rd(PD);
        rd(16'h0061);
        wr(PC, 8'h20, 3'd1); rd(PC); rd(PD); rd(PC);   // R12 control init via R4
        wr(PC, 8'hD0, 3'd1); rd(PD);                     // R12 output port init via R5
        // R7: pending ack survives write-output-port command
        wr(PD, 8'hED, 3'd1);
        wr(PC, 8'hD1, 3'd1); rd(PC);
        wr(PD, 8'h3C, 3'd1); rd(PC); rd(PD);
        wr(PC, 8'hD0, 3'd1); rd(PD);
        // R6: pending ack flushed by write-control command
        wr(PD, 8'hF4, 3'd1);
        wr(PC, 8'h60, 3'd1); rd(PC);
        wr(PD, 8'h47, 3'd1);
        wr(PC, 8'h20, 3'd1); rd(PD);
        // R4 flush: reply replaced, not queued
        wr(PD, 8'h00, 3'd1);
        wr(PC, 8'h20, 3'd1); rd(PD); rd(PD);
        // R3 back-to-back reset commands
        wr(PC, 8'hFE, 3'd1); wr(PC, 8'hFE, 3'd1); rd(PC);
        // R2 length sweep at both ports
        for (int l = 0; l < 8; l++) begin
            wr(PD, 8'h20, 3'(l)); wr(PC, 8'hFE, 3'(l)); rd(PC);
        end
        wr(PC, 8'h20, 3'd1); rd(PD);
        // R1 address sweep
        for (int a = 0; a < 256; a++) begin
            wr(16'(a) ^ 16'h0100, 8'hFE, 3'd1);
            wr(16'(a), 8'hD0, 3'd1);
            rd(PC); rd(PD);
        end
        // R10 full command byte sweep with a following data write
        for (int c = 0; c < 256; c++) begin
            wr(PC, 8'(c), 3'd1);
            wr(PD, 8'(c) ^ 8'h5A, 3'd1);
            rd(PC); rd(PD); rd(PC);
        end
        wr(PC, 8'h20, 3'd1); rd(PD);
        wr(PC, 8'hD0, 3'd1); rd(PD);
        // R11 saturation of all three counters
        for (int i = 0; i < 1100; i++) wr(PC, 8'hFE, 3'd1);
        for (int i = 0; i < 600; i++) wr(16'h0070, 8'h00, 3'd1);
        chk("R11 accepted saturated", int'(acc_count), CMAX);
        chk("R11 missed saturated", int'(miss_count), CMAX);
        chk("R11 reset saturated", int'(reset_count), CMAX);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule